// File: doc/BRIEF.md
# DMA Channel Result and Interrupt Unit

This block holds completion results and interrupt state for every channel of a multi-channel DMA controller, as seen by one execution environment. Channel engines report a finished transfer with a one-cycle `eng_done` strobe, and `eng_err` qualifies it as failed. The unit turns each report into a 32-bit result word. It keeps up to two such words per channel, and software takes them out by reading a per-channel result register. Reading pops the oldest entry.

Software sets up each channel through a channel configuration word and a result configuration word. It can abort a channel by writing that channel's flush register. That write is forwarded to the engine as a one-cycle pulse. When flush reporting is enabled, the write also queues a result marked as flushed and failed. The channel interrupt requests are merged into one `irq` line, and a source register holds one bit per channel.

Bus accesses use word addresses on `bus_addr`. The upper three bits select a register group and the lower bits select the channel. Writes take effect at the clock edge where `bus_wr` is high. Read data is registered: it appears one cycle after the `bus_rd` strobe, and it is zero in every cycle that does not follow a read.

Top module: `dma_result_irq_unit`

## Requirements
- R1: After synchronous reset every channel queue is empty, all configuration words read 0, and `irq`, `eng_flush` and `bus_rdata` are 0.
- R2: Reading the status register at address 0x10+i returns bit 1 set when channel i holds at least one result, and 0 in all other bits.
- R3: Reading the result register at address 0x00+i returns the oldest queued result of channel i on `bus_rdata` one cycle later, and removes it from the queue. An empty queue reads 0, and `bus_rdata` is 0 in any cycle not preceded by a read strobe.
- R4: An `eng_done[i]` strobe queues the word 0x8000_0002 (bit 31 valid, bit 1 transfer done). If `eng_err[i]` is also high, it queues 0x8000_000A (bit 3 error added).
- R5: Each channel holds at most two results in arrival order. A result that arrives while two are held is dropped, and bit 3 is set in the newer held result.
- R6: Bit i of the source register at address 0x50 is high when channel i has a queued result, its configuration bit 6 is set, and its result configuration bit 0 is set. `irq` is the OR of these bits.
- R7: The configuration register at 0x20+i keeps only bits 6, 7, 8, 9 and 11 of a write. The result configuration register at 0x30+i keeps only bits 0 and 1. Both read back what they keep.
- R8: A write to address 0x40+i drives `eng_flush[i]` high for exactly the one cycle after the write edge.
- R9: A flush write queues the word 0x8000_000C (valid, error, flushed) only when configuration bit 8 and result configuration bit 1 of that channel are both set. Otherwise it queues nothing.
- R10: When a flush write and `eng_done` reach the same channel in the same cycle, the completion report is discarded.
- R11: A read of a result register in the same cycle as a new arrival on that channel returns the previously queued head. The new arrival is kept.
- R12: Addresses outside the groups above, including 0x51 to 0x7F, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_done | input | NUM_CH | Per-channel transfer completion strobe |
| eng_err | input | NUM_CH | Per-channel failure qualifier for `eng_done` |
| eng_flush | output | NUM_CH | Per-channel abort pulse to the engines |
| irq | output | 1 | Merged interrupt request |

## Verification
Directed patterns cover three cases: a single completion, a failed completion on a channel with interrupts disabled, and three back-to-back completions. These tell apart the result encoding, the interrupt gating and the overflow marking. Flush writes go to an enabled channel and to a disabled one, and one flush shares its cycle with a completion, which separates the reporting enable from the abort pulse and exposes the priority. A read in the same cycle as an arrival, and accesses to unused addresses, probe the queue ordering and the decode. A long random run of mixed reads, writes and sparse completions is then compared cycle by cycle against a behavioural model, which catches ordering slips that the directed cases miss.

// File: rtl/dres_pkg.sv
// Package: shared constants and types for the DMA result and interrupt unit.
// Assumes a 32-bit register word and a three-bit register group field at the
// top of the word address.
package dres_pkg;

    localparam int WORD_W   = 32;
    localparam int REGION_W = 3;

    // Result word fields
    localparam int RES_VALID = 31;
    localparam int RES_ERR   = 3;
    localparam int RES_FLUSH = 2;
    localparam int RES_DONE  = 1;

    // Status word field
    localparam int STAT_PEND = 1;

    // Channel configuration fields
    localparam int CFG_IRQ_EN   = 6;
    localparam int CFG_FORCE    = 7;
    localparam int CFG_FLRES_EN = 8;
    localparam int CFG_PERM_PROT = 9;
    localparam int CFG_PROT_OFF = 11;

    // Result configuration fields
    localparam int RCFG_IRQ_EN   = 0;
    localparam int RCFG_FLRES_EN = 1;

    localparam logic [WORD_W-1:0] CFG_KEEP  = (WORD_W'(1) << CFG_IRQ_EN)   |
                                              (WORD_W'(1) << CFG_FORCE)    |
                                              (WORD_W'(1) << CFG_FLRES_EN) |
                                              (WORD_W'(1) << CFG_PERM_PROT) |
                                              (WORD_W'(1) << CFG_PROT_OFF);
    localparam logic [WORD_W-1:0] RCFG_KEEP = (WORD_W'(1) << RCFG_IRQ_EN) |
                                              (WORD_W'(1) << RCFG_FLRES_EN);

    typedef enum logic [REGION_W-1:0] {
        RG_RESULT = 3'd0,
        RG_STATUS = 3'd1,
        RG_CONF   = 3'd2,
        RG_RCONF  = 3'd3,
        RG_FLUSH  = 3'd4,
        RG_SOURCE = 3'd5
    } region_e;

    // Builds a result word from its event flags.
    function automatic logic [WORD_W-1:0] make_result(input logic is_flush,
                                                      input logic is_err);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RES_VALID] = 1'b1;
        if (is_flush) begin
            w[RES_FLUSH] = 1'b1;
            w[RES_ERR]   = 1'b1;
        end else begin
            w[RES_DONE] = 1'b1;
            w[RES_ERR]  = is_err;
        end
        return w;
    endfunction

endpackage

// File: rtl/dres_slot.sv
// Module: one channel's result store and configuration.
// Keeps a two-entry result queue, the channel and result configuration words
// and the abort pulse. Assumes pop, write and flush strobes are one cycle wide
// and already decoded for this channel.
module dres_slot
    import dres_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              rcfg_we,
    input  logic              flush_we,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ev_done,
    input  logic              ev_err,
    output logic [WORD_W-1:0] head_o,
    output logic              pend_o,
    output logic              irq_o,
    output logic [WORD_W-1:0] cfg_o,
    output logic [WORD_W-1:0] rcfg_o,
    output logic              flush_o
);

    logic [1:0]        cnt, cnt_n;
    logic [WORD_W-1:0] q0, q1, q0_n, q1_n;
    logic [WORD_W-1:0] cfg_q, rcfg_q;
    logic              flush_q;
    logic              pop_ok, flush_res, push;
    logic [WORD_W-1:0] new_word;

    // Purpose: next queue state from pop first, then at most one arrival.
    always_comb begin
        pop_ok    = pop && (cnt != 2'd0);
        flush_res = flush_we && cfg_q[CFG_FLRES_EN] && rcfg_q[RCFG_FLRES_EN];
        push      = flush_res || (ev_done && !flush_we);
        new_word  = make_result(flush_res, ev_err);
        q0_n  = q0;
        q1_n  = q1;
        cnt_n = cnt;
        if (pop_ok) begin
            q0_n  = q1;
            cnt_n = cnt - 2'd1;
        end
        if (push) begin
            case (cnt_n)
                2'd0: begin
                    q0_n  = new_word;
                    cnt_n = 2'd1;
                end
                2'd1: begin
                    q1_n  = new_word;
                    cnt_n = 2'd2;
                end
                default: q1_n[RES_ERR] = 1'b1;
            endcase
        end
    end

    // Purpose: queue registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 2'd0;
            q0  <= '0;
            q1  <= '0;
        end else begin
            cnt <= cnt_n;
            q0  <= q0_n;
            q1  <= q1_n;
        end
    end

    // Purpose: configuration words, keeping only defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            rcfg_q <= '0;
        end else begin
            if (cfg_we)  cfg_q  <= wdata & CFG_KEEP;
            if (rcfg_we) rcfg_q <= wdata & RCFG_KEEP;
        end
    end

    // Purpose: one-cycle abort pulse toward the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= flush_we;
    end

    assign head_o  = (cnt != 2'd0) ? q0 : '0;
    assign pend_o  = (cnt != 2'd0);
    assign irq_o   = pend_o && cfg_q[CFG_IRQ_EN] && rcfg_q[RCFG_IRQ_EN];
    assign cfg_o   = cfg_q;
    assign rcfg_o  = rcfg_q;
    assign flush_o = flush_q;

    AST_POP_LAST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd1 && pop && !ev_done && !flush_we) |=> !pend_o); // R3

    AST_OVERFLOW_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd2 && !pop && ev_done && !flush_we) |=> (cnt == 2'd2 && q1[RES_ERR])); // R5

endmodule

// File: rtl/dres_regbus.sv
// Module: register decode and registered read-back.
// Splits the word address into group and channel, produces per-channel write,
// flush and pop strobes, and registers read data (zero when no read).
// Assumes NUM_CH fits in the channel field and does not exceed WORD_W.
module dres_regbus
    import dres_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  heads,
    input  logic [NUM_CH-1:0]              pends,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  cfgs,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  rcfgs,
    input  logic [NUM_CH-1:0]              src,
    output logic [NUM_CH-1:0]              cfg_we,
    output logic [NUM_CH-1:0]              rcfg_we,
    output logic [NUM_CH-1:0]              flush_we,
    output logic [NUM_CH-1:0]              pop,
    output logic [WORD_W-1:0]              bus_rdata
);

    localparam int CH_W = ADDR_W - REGION_W;

    logic [REGION_W-1:0] region;
    logic [CH_W-1:0]     chan;
    logic                chan_ok;
    logic [NUM_CH-1:0]   sel;
    logic [WORD_W-1:0]   rd_val, src_word, stat_word;
    logic [WORD_W-1:0]   rdata_q;

    assign region  = bus_addr[ADDR_W-1:CH_W];
    assign chan    = bus_addr[CH_W-1:0];
    assign chan_ok = (int'(chan) < NUM_CH);

    // Purpose: one-hot channel select and per-group strobes.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            sel[i]      = chan_ok && (int'(chan) == i);
            cfg_we[i]   = bus_wr && sel[i] && (region == RG_CONF);
            rcfg_we[i]  = bus_wr && sel[i] && (region == RG_RCONF);
            flush_we[i] = bus_wr && sel[i] && (region == RG_FLUSH);
            pop[i]      = bus_rd && sel[i] && (region == RG_RESULT);
        end
    end

    // Purpose: select the read value from the addressed group.
    always_comb begin
        src_word = '0;
        src_word[NUM_CH-1:0] = src;
        stat_word = '0;
        rd_val = '0;
        if (chan_ok) begin
            stat_word[STAT_PEND] = pends[chan];
            case (region)
                RG_RESULT: rd_val = heads[chan];
                RG_STATUS: rd_val = stat_word;
                RG_CONF:   rd_val = cfgs[chan];
                RG_RCONF:  rd_val = rcfgs[chan];
                RG_SOURCE: rd_val = (chan == '0) ? src_word : '0;
                default:   rd_val = '0;
            endcase
        end
    end

    // Purpose: registered read data, zero in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0)); // R3

endmodule

// File: rtl/dres_irq_merge.sv
// Module: merges per-channel interrupt requests into the source vector and a
// single interrupt line. Purely combinational; assumes requests are already
// gated by both enables inside each channel.
module dres_irq_merge #(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH-1:0] chan_req,
    output logic [NUM_CH-1:0] src,
    output logic              irq
);

    // Purpose: source vector and OR reduction.
    always_comb begin
        src = chan_req;
        irq = |chan_req;
    end

endmodule

// File: rtl/dma_result_irq_unit.sv
// Module: top of the DMA channel result and interrupt unit.
// Instantiates one result slot per channel, the register decoder and the
// interrupt merge. Assumes ADDR_W leaves a three-bit group field above the
// channel field.
module dma_result_irq_unit
    import dres_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = $clog2(NUM_CH) + REGION_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0]  eng_done,
    input  logic [NUM_CH-1:0]  eng_err,
    output logic [NUM_CH-1:0]  eng_flush,
    output logic               irq
);

    logic [NUM_CH-1:0][WORD_W-1:0] heads, cfgs, rcfgs;
    logic [NUM_CH-1:0]             pends, reqs, src;
    logic [NUM_CH-1:0]             cfg_we, rcfg_we, flush_we, pop;

    dres_regbus #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regbus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .heads     (heads),
        .pends     (pends),
        .cfgs      (cfgs),
        .rcfgs     (rcfgs),
        .src       (src),
        .cfg_we    (cfg_we),
        .rcfg_we   (rcfg_we),
        .flush_we  (flush_we),
        .pop       (pop),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        dres_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[g]),
            .rcfg_we  (rcfg_we[g]),
            .flush_we (flush_we[g]),
            .pop      (pop[g]),
            .wdata    (bus_wdata),
            .ev_done  (eng_done[g]),
            .ev_err   (eng_err[g]),
            .head_o   (heads[g]),
            .pend_o   (pends[g]),
            .irq_o    (reqs[g]),
            .cfg_o    (cfgs[g]),
            .rcfg_o   (rcfgs[g]),
            .flush_o  (eng_flush[g])
        );
    end

    dres_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .chan_req (reqs),
        .src      (src),
        .irq      (irq)
    );

    AST_FLUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_flush)); // R8

    AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_flush != '0) |-> $past(bus_wr && (bus_addr[ADDR_W-1:ADDR_W-REGION_W] == RG_FLUSH))); // R8

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pends != '0)); // R6

endmodule

// File: tb/tb_dma_result_irq_unit.sv
module tb_dma_result_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int AW  = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [NCH-1:0] eng_done = '0;
    logic [NCH-1:0] eng_err = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] eng_flush;
    logic           irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_result_irq_unit #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .eng_flush (eng_flush),
        .irq       (irq)
    );

    // Behavioural reference model
    int             mcnt [NCH];
    logic [31:0]    mq   [NCH][$];
    logic [31:0]    mcfg [NCH];
    logic [31:0]    mrcfg[NCH];
    logic [31:0]    exp_rd = '0;
    logic [NCH-1:0] exp_fl = '0;
    string          rd_tag = "R1 reset rdata";
    int             nchk = 0;
    int             nerr = 0;
    bit             cmp_en = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] msrc();
        logic [NCH-1:0] s;
        for (int c = 0; c < NCH; c++)
            s[c] = (mq[c].size() != 0) && mcfg[c][6] && mrcfg[c][0];
        return s;
    endfunction

    task automatic mpush(input int c, input logic [31:0] w);
        if (mq[c].size() < 2) mq[c].push_back(w);
        else mq[c][1][3] = 1'b1;
    endtask

    always @(posedge clk) begin
        int grp, ch;
        logic [NCH-1:0] s;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                mq[c].delete();
                mcfg[c] = '0;
                mrcfg[c] = '0;
                mcnt[c] = 0;
            end
            exp_rd = '0;
            exp_fl = '0;
        end else begin
            grp = int'(bus_addr[6:4]);
            ch  = int'(bus_addr[3:0]);
            s = msrc();
            exp_rd = '0;
            rd_tag = "R3 idle rdata";
            if (bus_rd) begin
                case (grp)
                    0: begin exp_rd = (mq[ch].size() != 0) ? mq[ch][0] : 32'h0; rd_tag = "R3 result read"; end
                    1: begin exp_rd = (mq[ch].size() != 0) ? 32'h2 : 32'h0; rd_tag = "R2 status read"; end
                    2: begin exp_rd = mcfg[ch]; rd_tag = "R7 config read"; end
                    3: begin exp_rd = mrcfg[ch]; rd_tag = "R7 result config read"; end
                    5: begin exp_rd = (ch == 0) ? 32'(s) : 32'h0; rd_tag = "R6 source read"; end
                    default: begin exp_rd = '0; rd_tag = "R12 unmapped read"; end
                endcase
            end
            exp_fl = '0;
            if (bus_wr && grp == 4) exp_fl[ch] = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                bit fw;
                if (bus_rd && grp == 0 && ch == c && mq[c].size() != 0) void'(mq[c].pop_front());
                fw = bus_wr && grp == 4 && ch == c;
                if (fw) begin
                    if (mcfg[c][8] && mrcfg[c][1]) mpush(c, 32'h8000_000C);
                end else if (eng_done[c]) begin
                    mpush(c, eng_err[c] ? 32'h8000_000A : 32'h8000_0002);
                end
            end
            if (bus_wr && grp == 2) mcfg[ch]  = bus_wdata & 32'h0000_0BC0;
            if (bus_wr && grp == 3) mrcfg[ch] = bus_wdata & 32'h0000_0003;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(rd_tag, bus_rdata, exp_rd);
            chk("R6 irq line", {31'b0, irq}, {31'b0, |msrc()});
            chk("R8 flush pulse", 32'(eng_flush), 32'(exp_fl));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic ev(input logic [NCH-1:0] d, input logic [NCH-1:0] e);
        eng_done = d; eng_err = e;
        @(negedge clk);
        eng_done = '0; eng_err = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 flush after reset", 32'(eng_flush), 32'h0);
        rd(7'h20, v); chk("R1 config after reset", v, 32'h0);
        rd(7'h10, v); chk("R1 status after reset", v, 32'h0);

        wr(7'h23, 32'hFFFF_FFFF);
        rd(7'h23, v); chk("R7 config keeps bits", v, 32'h0000_0BC0);
        wr(7'h33, 32'hFFFF_FFFF);
        rd(7'h33, v); chk("R7 result config keeps bits", v, 32'h0000_0003);

        ev(16'h0008, 16'h0);
        chk("R6 irq raised", {31'b0, irq}, 32'h1);
        rd(7'h50, v); chk("R6 source bit 3", v, 32'h0000_0008);
        rd(7'h13, v); chk("R2 status pending", v, 32'h2);
        rd(7'h03, v); chk("R4 done result", v, 32'h8000_0002);
        chk("R3 irq drops after pop", {31'b0, irq}, 32'h0);
        rd(7'h13, v); chk("R3 status clear after pop", v, 32'h0);

        ev(16'h0020, 16'h0020);
        chk("R6 no irq without enables", {31'b0, irq}, 32'h0);
        rd(7'h05, v); chk("R4 failed result", v, 32'h8000_000A);

        ev(16'h0080, 16'h0); ev(16'h0080, 16'h0); ev(16'h0080, 16'h0);
        rd(7'h07, v); chk("R5 first kept", v, 32'h8000_0002);
        rd(7'h07, v); chk("R5 second flagged", v, 32'h8000_000A);
        rd(7'h07, v); chk("R5 third dropped", v, 32'h0);

        wr(7'h43, 32'h0);
        chk("R8 flush pulse ch3", 32'(eng_flush), 32'h0000_0008);
        rd(7'h03, v); chk("R9 flush result", v, 32'h8000_000C);
        chk("R8 flush pulse ends", 32'(eng_flush), 32'h0);
        wr(7'h42, 32'h0);
        rd(7'h12, v); chk("R9 no result when disabled", v, 32'h0);

        eng_done = 16'h0008; bus_addr = 7'h43; bus_wr = 1'b1;
        @(negedge clk);
        eng_done = '0; bus_wr = 1'b0;
        rd(7'h03, v); chk("R10 flush result wins", v, 32'h8000_000C);
        rd(7'h03, v); chk("R10 completion discarded", v, 32'h0);

        ev(16'h0010, 16'h0);
        bus_addr = 7'h04; bus_rd = 1'b1; eng_done = 16'h0010; eng_err = 16'h0010;
        @(negedge clk);
        bus_rd = 1'b0; eng_done = '0; eng_err = '0;
        chk("R11 read returns old head", bus_rdata, 32'h8000_0002);
        rd(7'h04, v); chk("R11 arrival kept", v, 32'h8000_000A);

        wr(7'h60, 32'hFFFF_FFFF);
        rd(7'h60, v); chk("R12 unmapped reads zero", v, 32'h0);
        rd(7'h51, v); chk("R12 source alias zero", v, 32'h0);
        rd(7'h23, v); chk("R12 config untouched", v, 32'h0000_0BC0);

        for (int n = 0; n < 3000; n++) begin
            bus_addr  = AW'($urandom);
            bus_wdata = $urandom;
            bus_wr    = ($urandom % 8) == 0;
            bus_rd    = !bus_wr && (($urandom % 3) == 0);
            eng_done  = NCH'($urandom & $urandom & $urandom);
            eng_err   = NCH'($urandom);
            @(negedge clk);
        end
        bus_wr = 1'b0; bus_rd = 1'b0; eng_done = '0; eng_err = '0;
        @(negedge clk);
        finish_run();
    end

endmodule